// File: doc/BRIEF.md
# Phase-Programmable Pixel Data Output Retimer

This block takes one converted pixel sample per pixel period and puts it out on a parallel data bus, together with a companion data clock. Each pixel period has 48 fast-clock steps, counted by a phase index that is shared with the rest of the timing core. A programmable launch phase selects the fast-clock step at which the output bus updates. Samples pass through a fixed pipeline, so that the sample captured in one pixel period is launched eleven pixel periods later.

The data clock has two modes. In tracking mode it rises together with the data launch and falls half a pixel period later. In fixed mode it follows the inverse of the pixel clock: the pixel clock is taken as high for steps 0 to 23 and low for steps 24 to 47. A two-bit output-delay trim field sits in the same configuration word. It is stored and read back, and it has no effect on timing. All configuration is written through a single write-enable port, and the stored word is always visible on a readback port.

Top module: `dout_phase_retimer`

## Requirements
- R1: While reset is asserted and right after it, dataOut is 0, dataValid is 0 and dclk is 0. regRdData reads 9'h100, which is phase 0, tracking mode and trim code 2.
- R2: A cycle with regWrEn high loads the configuration word. Bits [5:0] are the launch phase, bit 6 is the fixed-clock mode and bits [8:7] are the trim code. From the next cycle on, regRdData shows the word and the logic uses it.
- R3: A write whose phase field is above 47 leaves the stored phase unchanged. The mode and trim fields of that same write are still stored.
- R4: dataOut and dataValid change only at the clock edge that ends a cycle whose phaseIdx equals the stored launch phase. At every other edge they hold.
- R5: sampleIn is captured at the edge that ends the cycle with phaseIdx 47. The sample captured in pixel period N is launched at the launch edge of period N+11.
- R6: dataValid stays low, and dataOut reads 0, until eleven samples have been captured since reset. dataValid goes high with the first launch after that and then stays high until the next reset.
- R7: In tracking mode (bit 6 = 0), dclk goes to 1 after the cycle whose phaseIdx equals the launch phase. It goes to 0 after the cycle whose phaseIdx equals the launch phase plus 24, modulo 48. At all other edges it holds.
- R8: In fixed mode (bit 6 = 1), dclk is 1 exactly one cycle after a cycle with phaseIdx of 24 or more, and 0 otherwise. The data launch phase still follows bits [5:0].
- R9: The trim code has no effect on dataOut, dataValid or dclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 cycles per pixel period |
| rst_n | input | 1 | Asynchronous reset, active low |
| phaseIdx | input | 6 | Shared phase step within the pixel period, 0..47 |
| sampleIn | input | 12 | Converted pixel sample, held over its pixel period |
| regWrEn | input | 1 | Configuration write strobe |
| regWrData | input | 9 | Configuration word to write |
| regRdData | output | 9 | Stored configuration word |
| dataOut | output | 12 | Retimed pixel data |
| dataValid | output | 1 | High once the pipeline holds real samples |
| dclk | output | 1 | Companion data clock |

## Verification
The launch phase is swept over all 48 values in tracking mode and then again in fixed mode. Sweeping the phase shows whether the launch edge, and the dclk rise and fall edges half a period apart, land on the programmed step and nowhere else. Sweeping in both modes shows that the fixed clock ignores the launch phase while the data still obeys it. The sample values change every period with a non-repeating arithmetic pattern, so a pipeline that is one stage too long or too short produces a wrong value rather than a coincidental match. A reset in the middle of the run, plus writes with out-of-range phases and with every trim code, cover the valid-flag startup, the ignore rule and the inert trim field.

// File: rtl/retimer_pkg.sv
package retimer_pkg;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic shift;      // advance the latency pipeline
    logic load;       // launch the oldest stage onto the output
    logic dclkRise;   // tracking mode: drive dclk high
    logic dclkFall;   // tracking mode: drive dclk low
    logic fixedMode;  // dclk follows the inverted pixel clock
    logic fixedLevel; // level of the inverted pixel clock this step
  } retimerStrobes_t;

endpackage

// File: rtl/retimer_ctrl.sv
module retimer_ctrl
  import retimer_pkg::*;
#(
  parameter int PHASES     = 48,
  parameter int TRIM_W     = 2,
  parameter int TRIM_RESET = 2,
  localparam int PHASE_W   = $clog2(PHASES),
  localparam int CFG_W     = PHASE_W + 1 + TRIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phaseIdx,
  input  logic               regWrEn,
  input  logic [CFG_W-1:0]   regWrData,
  output logic [CFG_W-1:0]   regRdData,
  output retimerStrobes_t    strobes
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PHASES - 1);
  localparam logic [PHASE_W-1:0] HALF_PHASE = PHASE_W'(PHASES / 2);
  localparam logic [PHASE_W:0]   PHASES_X   = (PHASE_W+1)'(PHASES);
  localparam int MODE_BIT = PHASE_W;

  logic [PHASE_W-1:0] cfgPhase;
  logic               cfgFixed;
  logic [TRIM_W-1:0]  cfgTrim;

  logic [PHASE_W-1:0] wrPhase;
  logic [PHASE_W:0]   fallSum;
  logic [PHASE_W-1:0] fallPhase;

  assign wrPhase = regWrData[PHASE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgPhase <= '0;
      cfgFixed <= 1'b0;
      cfgTrim  <= TRIM_W'(TRIM_RESET);
    end else if (regWrEn) begin
      if (wrPhase <= LAST_PHASE) cfgPhase <= wrPhase;
      cfgFixed <= regWrData[MODE_BIT];
      cfgTrim  <= regWrData[CFG_W-1:MODE_BIT+1];
    end
  end

  assign regRdData = {cfgTrim, cfgFixed, cfgPhase};

  // Fall step is half a period after the launch step, wrapped.
  always_comb begin
    fallSum = {1'b0, cfgPhase} + {1'b0, HALF_PHASE};
    if (fallSum >= PHASES_X) fallPhase = PHASE_W'(fallSum - PHASES_X);
    else                     fallPhase = fallSum[PHASE_W-1:0];
  end

  always_comb begin
    strobes.shift      = (phaseIdx == LAST_PHASE);
    strobes.load       = (phaseIdx == cfgPhase);
    strobes.dclkRise   = !cfgFixed && (phaseIdx == cfgPhase);
    strobes.dclkFall   = !cfgFixed && (phaseIdx == fallPhase);
    strobes.fixedMode  = cfgFixed;
    strobes.fixedLevel = (phaseIdx >= HALF_PHASE);
  end

endmodule

// File: rtl/retimer_datapath.sv
module retimer_datapath
  import retimer_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int LATENCY = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  retimerStrobes_t   strobes,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              dclk
);

  logic [LATENCY-1:0][DATA_W-1:0] stageData;
  logic [LATENCY-1:0][DATA_W-1:0] stageNext;
  logic [LATENCY-1:0]             stageValid;
  logic [LATENCY-1:0]             validNext;

  for (genvar g = 0; g < LATENCY; g++) begin : gStage
    if (g == 0) begin : gHead
      assign stageNext[g] = sampleIn;
      assign validNext[g] = 1'b1;
    end else begin : gBody
      assign stageNext[g] = stageData[g-1];
      assign validNext[g] = stageValid[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stageData  <= '0;
      stageValid <= '0;
    end else if (strobes.shift) begin
      stageData  <= stageNext;
      stageValid <= validNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else if (strobes.load) begin
      dataOut   <= stageData[LATENCY-1];
      dataValid <= stageValid[LATENCY-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dclk <= 1'b0;
    else if (strobes.fixedMode) dclk <= strobes.fixedLevel;
    else if (strobes.dclkRise)  dclk <= 1'b1;
    else if (strobes.dclkFall)  dclk <= 1'b0;
  end

endmodule

// File: rtl/dout_phase_retimer.sv
module dout_phase_retimer
  import retimer_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int PHASES     = 48,
  parameter int LATENCY    = 11,
  parameter int TRIM_W     = 2,
  parameter int TRIM_RESET = 2,
  localparam int PHASE_W   = $clog2(PHASES),
  localparam int CFG_W     = PHASE_W + 1 + TRIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phaseIdx,
  input  logic [DATA_W-1:0]  sampleIn,
  input  logic               regWrEn,
  input  logic [CFG_W-1:0]   regWrData,
  output logic [CFG_W-1:0]   regRdData,
  output logic [DATA_W-1:0]  dataOut,
  output logic               dataValid,
  output logic               dclk
);

  retimerStrobes_t strobes;

  retimer_ctrl #(
    .PHASES(PHASES), .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .phaseIdx(phaseIdx),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .strobes(strobes)
  );

  retimer_datapath #(
    .DATA_W(DATA_W), .LATENCY(LATENCY)
  ) uPath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .sampleIn(sampleIn),
    .dataOut(dataOut), .dataValid(dataValid), .dclk(dclk)
  );

endmodule

// File: rtl/dout_phase_retimer_checker.sv
module dout_phase_retimer_checker #(
  parameter int DATA_W   = 12,
  parameter int PHASES   = 48,
  parameter int TRIM_W   = 2,
  localparam int PHASE_W = $clog2(PHASES),
  localparam int CFG_W   = PHASE_W + 1 + TRIM_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PHASE_W-1:0] phaseIdx,
  input logic               regWrEn,
  input logic [CFG_W-1:0]   regWrData,
  input logic [CFG_W-1:0]   regRdData,
  input logic [DATA_W-1:0]  dataOut,
  input logic               dataValid,
  input logic               dclk
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PHASES - 1);
  localparam logic [PHASE_W-1:0] HALF_PHASE = PHASE_W'(PHASES / 2);

  logic [PHASE_W-1:0] curPhase;
  logic               curFixed;
  logic [PHASE_W:0]   fallSum;
  logic [PHASE_W-1:0] fallStep;

  assign curPhase = regRdData[PHASE_W-1:0];
  assign curFixed = regRdData[PHASE_W];
  assign fallSum  = {1'b0, curPhase} + {1'b0, HALF_PHASE};
  assign fallStep = (fallSum > {1'b0, LAST_PHASE}) ?
                    PHASE_W'(fallSum - (PHASE_W+1)'(PHASES)) : fallSum[PHASE_W-1:0];

  // R3: an out-of-range phase write leaves the stored phase alone
  assert_bad_phase_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regWrData[PHASE_W-1:0] > LAST_PHASE) |=> $stable(regRdData[PHASE_W-1:0]));

  // R4: output changes only after the launch step
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (dataOut != $past(dataOut) || dataValid != $past(dataValid)))
      |-> ($past(phaseIdx) == $past(curPhase)));

  // R6: valid never drops outside reset
  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(dataValid));

  // R7: tracking-mode rise after launch step
  assert_track_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(curFixed) && $past(phaseIdx) == $past(curPhase)) |-> dclk);

  // R7: tracking-mode fall half a period later
  assert_track_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(curFixed) && $past(phaseIdx) == $past(fallStep)) |-> !dclk);

  // R8: fixed mode follows the inverted pixel clock, one cycle late
  assert_fixed_dclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(curFixed)) |-> (dclk == ($past(phaseIdx) >= HALF_PHASE)));

endmodule

bind dout_phase_retimer dout_phase_retimer_checker #(
  .DATA_W(DATA_W), .PHASES(PHASES), .TRIM_W(TRIM_W)
) uChecker (
  .clk(clk), .rst_n(rst_n), .phaseIdx(phaseIdx),
  .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
  .dataOut(dataOut), .dataValid(dataValid), .dclk(dclk)
);

// File: tb/tb_dout_phase_retimer.sv
`timescale 1ns/1ps
module tb_dout_phase_retimer;

  localparam int PER = 48;
  localparam int LAT = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  phaseIdx = '0;
  logic [11:0] sampleIn = '0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regWrData = '0;
  logic [8:0]  regRdData;
  logic [11:0] dataOut;
  logic        dataValid;
  logic        dclk;

  dout_phase_retimer dut (
    .clk(clk), .rst_n(rst_n), .phaseIdx(phaseIdx), .sampleIn(sampleIn),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .dataOut(dataOut), .dataValid(dataValid), .dclk(dclk)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench-side model state
  int phaseCnt = PER - 1;
  int period = 0;
  int samplesIn = 0;
  int expPhase = 0;
  bit expFixed = 0;
  int expTrim = 2;
  logic [11:0] expOut = '0;
  bit expValid = 0;
  bit expDclk = 0;
  bit wrPend = 0;
  logic [8:0] wrVal = '0;

  function automatic logic [11:0] pat(int p);
    return 12'((p * 1103 + 77) ^ (p << 5));
  endfunction

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h phase=%0d period=%0d",
               tag, act, exp, phaseCnt, period);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    phaseCnt = (phaseCnt + 1) % PER;
    if (phaseCnt == 0) period++;
    phaseIdx  = 6'(phaseCnt);
    sampleIn  = pat(period);
    regWrEn   = wrPend;
    regWrData = wrVal;
    wrPend    = 0;
    @(posedge clk);
    if (!rst_n) begin
      expOut = '0; expValid = 0; expDclk = 0;
      expPhase = 0; expFixed = 0; expTrim = 2; samplesIn = 0;
    end else begin
      if (phaseCnt == expPhase) begin
        expValid = (samplesIn >= LAT);
        expOut   = expValid ? pat(period - LAT) : 12'h000;
      end
      if (expFixed) expDclk = (phaseCnt >= PER / 2);
      else if (phaseCnt == expPhase) expDclk = 1;
      else if (phaseCnt == (expPhase + PER / 2) % PER) expDclk = 0;
      if (phaseCnt == PER - 1) samplesIn++;
      if (regWrEn) begin
        if (int'(regWrData[5:0]) < PER) expPhase = int'(regWrData[5:0]);
        expFixed = regWrData[6];
        expTrim  = int'(regWrData[8:7]);
      end
    end
    #1;
    check(int'(dataOut), int'(expOut), "R5 dataOut");
    check(int'(dataValid), int'(expValid), "R6 dataValid");
    check(int'(dclk), int'(expDclk), expFixed ? "R8 dclk" : "R7 dclk");
    check(int'(regRdData), (expTrim << 7) | (int'(expFixed) << 6) | expPhase, "R2 regRdData");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic writeCfg(int trim, bit fixedMode, int ph);
    wrPend = 1;
    wrVal  = 9'((trim << 7) | (int'(fixedMode) << 6) | ph);
    cycle();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    run(10);
    // R1: reset state
    check(int'(dataOut), 0, "R1 reset dataOut");
    check(int'(dataValid), 0, "R1 reset dataValid");
    check(int'(dclk), 0, "R1 reset dclk");
    check(int'(regRdData), 9'h100, "R1 reset regRdData");
    rst_n = 1'b1;
    run(PER * 5);
    // R6: still invalid before eleven samples
    check(int'(dataValid), 0, "R6 early valid");
    run(PER * 9);

    // R4 R5 R7: tracking sweep over every launch phase
    for (int p = 0; p < PER; p++) begin
      writeCfg(2, 0, p);
      run(PER * 4);
    end

    // R3: out-of-range phase ignored, other fields stored
    writeCfg(2, 0, 17);
    run(PER);
    writeCfg(1, 0, 50);
    run(3);
    check(int'(regRdData[5:0]), 17, "R3 phase kept");
    check(int'(regRdData[8:7]), 1, "R3 trim stored");
    writeCfg(3, 1, 63);
    run(3);
    check(int'(regRdData[6]), 1, "R3 mode stored");
    check(int'(regRdData[5:0]), 17, "R3 phase kept again");

    // R8 R9: fixed-mode sweep, trim code varied on every step
    for (int p = 0; p < PER; p++) begin
      writeCfg(p % 4, 1, p);
      run(PER * 3);
    end

    // R9: trim swept under tracking mode with fixed launch phase
    for (int t = 0; t < 4; t++) begin
      writeCfg(t, 0, 30);
      run(PER * 2);
    end

    // R6: reset mid-run then restart the pipeline
    rst_n = 1'b0;
    run(7);
    check(int'(dataValid), 0, "R6 valid cleared by reset");
    check(int'(regRdData), 9'h100, "R1 config after reset");
    rst_n = 1'b1;
    writeCfg(2, 0, 47);
    run(PER * 10);
    check(int'(dataValid), 0, "R6 invalid before eleventh sample");
    run(PER * 4);
    check(int'(dataValid), 1, "R6 valid after eleven samples");
    writeCfg(0, 1, 5);
    run(PER * 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule